// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block decides when each decoded three-address instruction may leave decode, and when each functional unit may read its operands and write its result. Fetch and decode present one instruction at a time: the target unit, an operation code, and a destination register with two source registers. Each functional unit reports back with two signals. One says it has captured its operands. The other asks to write its result.

The block keeps a status record for each unit. The record holds a busy bit, the operation, the three register designators, a producer tag for each source and a ready flag for each source. The block also keeps one pending-producer tag for each architectural register. Producer tags are 4 bits wide. Tag 8 means "no result pending". The other fifteen values name units:

| Tag | Unit |
|---|---|
| 0 | branch |
| 1, 2 | increment |
| 3 | shift |
| 4 | boolean |
| 5 | divide |
| 6, 7 | multiply |
| 9 to 13 | load buffers |
| 14 | long add |
| 15 | add |

The block handles four kinds of conflict:
- A structural conflict (the unit is busy) holds the instruction at issue.
- A write-after-write conflict (the destination already has a pending result) also holds it at issue.
- A read-after-write conflict holds back the operand read until the producer writes.
- A write-after-read conflict holds back the producer's write until every earlier reader has taken the old value. Issue is not stalled for this case.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After synchronous reset, no unit is busy and every register has tag 8. `issue_o`, `go_read` and `go_store` are all zero, even with every `rel_req` bit high.
- R2: An instruction whose target unit is busy is not issued. `stall` is high and `issue_o` is zero.
- R3: An instruction whose destination register has a pending result (tag not 8) is not issued, even when its unit is free.
- R4: An accepted instruction raises exactly the `issue_o` bit that equals its unit code, in the same cycle. From the next cycle, `unit_op` for that unit holds the operation and the destination register counts as pending.
- R5: A source register with no pending producer counts as ready at issue. The unit's `go_read` rises in the cycle after issue if both sources are ready.
- R6: A source waiting on a producer keeps `go_read` low. It becomes ready when that producer's `go_store` is seen, and `go_read` rises in the following cycle.
- R7: When `rd_done` is high while `go_read` is high, both ready flags of that unit clear and `go_read` is low in the next cycle.
- R8: A unit requesting release gets no `go_store` while any busy unit holds a set ready flag on that destination register (write-after-read). The grant appears in the cycle after that reader's `rd_done`.
- R9: After a unit's `go_store`, the unit's busy flag and the destination's pending tag clear at the next edge. A new instruction to that unit, writing that register, issues one cycle later.
- R10: While the branch unit (code 0) is busy, no instruction issues, up to and including its `go_store` cycle.
- R11: Units releasing to distinct registers are all granted `go_store` in the same cycle. Where two share a register, only the lowest unit code is granted.
- R12: Unit code 8 names no unit. An instruction with that code is never issued and holds `stall` high.
- R13: If a source register's producer receives `go_store` in the same cycle that a consumer issues, that source counts as ready at issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A decoded instruction is presented |
| iss_unit | input | 4 | Target unit code |
| iss_op | input | 6 | Operation code for the unit |
| iss_fi | input | 5 | Destination register (0 to 23) |
| iss_fj | input | 5 | First source register |
| iss_fk | input | 5 | Second source register |
| rel_req | input | 16 | Per-unit request to write its result |
| rd_done | input | 16 | Per-unit indication that operands were captured |
| issue_o | output | 16 | Per-unit issue pulse |
| unit_op | output | 16x6 | Operation held by each unit |
| go_read | output | 16 | Per-unit permission to read operands |
| go_store | output | 16 | Per-unit permission to write the result |
| stall | output | 1 | Presented instruction cannot issue this cycle |

## Verification
The hardest situations to reach are the write-after-read hold and the same-cycle hand-off.

For the write-after-read hold, a later instruction must overwrite a register that an earlier unit has flagged ready but not yet read. The stimulus issues an add that reads register 1, then a boolean operation that writes register 1. It keeps `rel_req` high for the boolean unit while withholding the add's `rd_done` for two cycles, so the missing grant can be observed before it is released.

For the same-cycle hand-off (R13), a consumer is issued in exactly the cycle its producer is granted `go_store`. The bench then shows that the consumer's `go_read` still rises.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int NUM_UNITS = 16;
    localparam int TAG_W     = $clog2(NUM_UNITS);
    localparam int NUM_REGS  = 24;
    localparam int REG_W     = $clog2(NUM_REGS);
    localparam int OP_W      = 6;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [REG_W-1:0] reg_t;
    typedef logic [OP_W-1:0]  op_t;

    // Tag value reserved for "no result pending"; it names no unit.
    localparam tag_t TAG_NONE   = tag_t'(8);
    // Unit whose activity blocks all further issue.
    localparam tag_t TAG_BRANCH = tag_t'(0);

    typedef struct packed {
        logic valid;
        tag_t unit;
        op_t  op;
        reg_t fi;
        reg_t fj;
        reg_t fk;
    } iss_req_t;

    typedef struct packed {
        logic busy;
        op_t  op;
        reg_t fi;
        reg_t fj;
        reg_t fk;
        tag_t qj;
        tag_t qk;
        logic rj;
        logic rk;
    } unit_stat_t;

    localparam unit_stat_t UNIT_IDLE = '{busy: 1'b0, op: '0, fi: '0, fj: '0, fk: '0,
                                         qj: TAG_NONE, qk: TAG_NONE, rj: 1'b0, rk: 1'b0};

    // A source is ready at issue when nothing is pending on it, or when its
    // producer is writing back in this very cycle.
    function automatic logic src_ready(tag_t q, logic [NUM_UNITS-1:0] storing);
        return (q == TAG_NONE) || storing[q];
    endfunction

endpackage

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_me,
    input  iss_req_t             req,
    input  logic                 rdy_j,
    input  logic                 rdy_k,
    input  tag_t                 qj_in,
    input  tag_t                 qk_in,
    input  logic [NUM_UNITS-1:0] bcast,
    input  logic                 rd_done_me,
    input  logic                 go_store_me,
    output unit_stat_t           st,
    output logic                 go_read
);

    assign go_read = st.busy & st.rj & st.rk;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= UNIT_IDLE;
        end else if (issue_me) begin
            st.busy <= 1'b1;
            st.op   <= req.op;
            st.fi   <= req.fi;
            st.fj   <= req.fj;
            st.fk   <= req.fk;
            st.rj   <= rdy_j;
            st.rk   <= rdy_k;
            st.qj   <= rdy_j ? TAG_NONE : qj_in;
            st.qk   <= rdy_k ? TAG_NONE : qk_in;
        end else begin
            if (go_store_me) begin
                st.busy <= 1'b0;
            end
            if (go_read && rd_done_me) begin
                st.rj <= 1'b0;
                st.rk <= 1'b0;
            end else begin
                if (!st.rj && st.qj != TAG_NONE && bcast[st.qj]) begin
                    st.rj <= 1'b1;
                    st.qj <= TAG_NONE;
                end
                if (!st.rk && st.qk != TAG_NONE && bcast[st.qk]) begin
                    st.rk <= 1'b1;
                    st.qk <= TAG_NONE;
                end
            end
        end
    end

    assert_no_issue_when_busy_R2: assert property (@(posedge clk) disable iff (rst)
        issue_me |-> !st.busy);

    assert_read_flags_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (go_read && rd_done_me) |=> !go_read);

    assert_busy_after_issue_R4: assert property (@(posedge clk) disable iff (rst)
        issue_me |=> st.busy);

endmodule

// File: rtl/sb_result_tags.sv
module sb_result_tags
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_en,
    input  reg_t                 iss_fi,
    input  tag_t                 iss_unit,
    input  logic [NUM_UNITS-1:0] go_store,
    input  reg_t                 fi_of [NUM_UNITS],
    output tag_t                 res_id [NUM_REGS]
);

    logic [NUM_REGS-1:0] clr;

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            clr[r] = 1'b0;
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (go_store[u] && fi_of[u] == reg_t'(r) && res_id[r] == tag_t'(u)) begin
                    clr[r] = 1'b1;
                end
            end
        end
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_id[r] <= TAG_NONE;
            end else if (issue_en && iss_fi == reg_t'(r)) begin
                res_id[r] <= iss_unit;
            end else if (clr[r]) begin
                res_id[r] <= TAG_NONE;
            end
        end

        // A pending tag is never replaced by another producer (R3).
        assert_pending_kept_R3: assert property (@(posedge clk) disable iff (rst)
            (res_id[r] != TAG_NONE) |=> (res_id[r] == $past(res_id[r]) || res_id[r] == TAG_NONE));
    end

    assert_dest_marked_R4: assert property (@(posedge clk) disable iff (rst)
        issue_en |=> res_id[$past(iss_fi)] == $past(iss_unit));

endmodule

// File: rtl/sb_store_grant.sv
module sb_store_grant
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  unit_stat_t           st [NUM_UNITS],
    input  logic [NUM_UNITS-1:0] rel_req,
    output logic [NUM_UNITS-1:0] go_store
);

    logic [NUM_REGS-1:0]  all_clear;
    logic [NUM_UNITS-1:0] cand;

    // A register is clear when no busy unit still owes a read of it.
    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            all_clear[r] = 1'b1;
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (st[u].busy && ((st[u].rj && st[u].fj == reg_t'(r)) ||
                                   (st[u].rk && st[u].fk == reg_t'(r)))) begin
                    all_clear[r] = 1'b0;
                end
            end
        end
    end

    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            cand[u] = st[u].busy && rel_req[u] && all_clear[st[u].fi];
        end
    end

    // Per destination register, the lowest unit code wins.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            go_store[u] = cand[u];
            for (int v = 0; v < u; v++) begin
                if (cand[v] && st[v].fi == st[u].fi) begin
                    go_store[u] = 1'b0;
                end
            end
        end
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        assert_busy_clears_R9: assert property (@(posedge clk) disable iff (rst)
            go_store[u] |=> !st[u].busy);
    end

endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
    import sb_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           iss_valid,
    input  logic [TAG_W-1:0]               iss_unit,
    input  logic [OP_W-1:0]                iss_op,
    input  logic [REG_W-1:0]               iss_fi,
    input  logic [REG_W-1:0]               iss_fj,
    input  logic [REG_W-1:0]               iss_fk,
    input  logic [NUM_UNITS-1:0]           rel_req,
    input  logic [NUM_UNITS-1:0]           rd_done,
    output logic [NUM_UNITS-1:0]           issue_o,
    output logic [NUM_UNITS-1:0][OP_W-1:0] unit_op,
    output logic [NUM_UNITS-1:0]           go_read,
    output logic [NUM_UNITS-1:0]           go_store,
    output logic                           stall
);

    iss_req_t             req;
    unit_stat_t           st     [NUM_UNITS];
    reg_t                 fi_of  [NUM_UNITS];
    tag_t                 res_id [NUM_REGS];
    logic [NUM_UNITS-1:0] busy_vec;
    logic                 can_issue;
    tag_t                 qj_raw, qk_raw;
    logic                 rdy_j, rdy_k;

    assign req = '{valid: iss_valid, unit: iss_unit, op: iss_op,
                   fi: iss_fi, fj: iss_fj, fk: iss_fk};

    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            busy_vec[u] = st[u].busy;
            fi_of[u]    = st[u].fi;
            unit_op[u]  = st[u].op;
        end
    end

    assign qj_raw = res_id[req.fj];
    assign qk_raw = res_id[req.fk];
    assign rdy_j  = src_ready(qj_raw, go_store);
    assign rdy_k  = src_ready(qk_raw, go_store);

    assign can_issue = req.valid
                    && (req.unit != TAG_NONE)
                    && (req.fi < reg_t'(NUM_REGS))
                    && !busy_vec[req.unit]
                    && (res_id[req.fi] == TAG_NONE)
                    && !busy_vec[TAG_BRANCH];

    assign stall = req.valid && !can_issue;

    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            issue_o[u] = can_issue && (req.unit == tag_t'(u));
        end
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        sb_unit_slot u_slot (
            .clk         (clk),
            .rst         (rst),
            .issue_me    (issue_o[u]),
            .req         (req),
            .rdy_j       (rdy_j),
            .rdy_k       (rdy_k),
            .qj_in       (qj_raw),
            .qk_in       (qk_raw),
            .bcast       (go_store),
            .rd_done_me  (rd_done[u]),
            .go_store_me (go_store[u]),
            .st          (st[u]),
            .go_read     (go_read[u])
        );
    end

    sb_result_tags u_tags (
        .clk      (clk),
        .rst      (rst),
        .issue_en (can_issue),
        .iss_fi   (req.fi),
        .iss_unit (req.unit),
        .go_store (go_store),
        .fi_of    (fi_of),
        .res_id   (res_id)
    );

    sb_store_grant u_grant (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .rel_req  (rel_req),
        .go_store (go_store)
    );

    assert_single_issue_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_o));

    assert_branch_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        issue_o[TAG_BRANCH] |=> (issue_o == '0));

endmodule

// File: tb/tb_sb_hazard_ctrl.sv
module tb_sb_hazard_ctrl;
    import sb_pkg::*;

    logic                           clk = 1'b0;
    logic                           rst;
    logic                           iss_valid;
    logic [TAG_W-1:0]               iss_unit;
    logic [OP_W-1:0]                iss_op;
    logic [REG_W-1:0]               iss_fi, iss_fj, iss_fk;
    logic [NUM_UNITS-1:0]           rel_req, rd_done;
    logic [NUM_UNITS-1:0]           issue_o, go_read, go_store;
    logic [NUM_UNITS-1:0][OP_W-1:0] unit_op;
    logic                           stall;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #4 clk = ~clk;

    sb_hazard_ctrl dut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_unit(iss_unit),
        .iss_op(iss_op), .iss_fi(iss_fi), .iss_fj(iss_fj), .iss_fk(iss_fk),
        .rel_req(rel_req), .rd_done(rd_done), .issue_o(issue_o),
        .unit_op(unit_op), .go_read(go_read), .go_store(go_store), .stall(stall)
    );

    typedef struct packed {
        logic [3:0] unit;
        logic [4:0] fi;
        logic [4:0] fj;
        logic [4:0] fk;
        logic       accept;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{4'd15, 5'd6,  5'd1, 5'd2, 1'b1},   // R4 add accepted
        '{4'd15, 5'd5,  5'd1, 5'd2, 1'b0},   // R2 add busy
        '{4'd6,  5'd6,  5'd1, 5'd2, 1'b0},   // R3 register 6 pending
        '{4'd6,  5'd7,  5'd6, 5'd3, 1'b1},   // R4 multiply waits on add
        '{4'd8,  5'd9,  5'd1, 5'd1, 1'b0},   // R12 code 8
        '{4'd7,  5'd10, 5'd1, 5'd1, 1'b1},   // R4 second multiply
        '{4'd0,  5'd20, 5'd7, 5'd0, 1'b1},   // R4 branch accepted
        '{4'd4,  5'd11, 5'd1, 5'd1, 1'b0}    // R10 branch busy
    };

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic drv(input logic [3:0] u, input logic [4:0] fi, input logic [4:0] fj,
                       input logic [4:0] fk);
        iss_valid = 1'b1; iss_unit = u; iss_op = {2'b00, u};
        iss_fi = fi; iss_fj = fj; iss_fk = fk;
    endtask

    task automatic idle();
        iss_valid = 1'b0; iss_unit = '0; iss_op = '0; iss_fi = '0; iss_fj = '0; iss_fk = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; idle(); rel_req = '0; rd_done = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [15:0] bit1(input int u);
        return 16'(1) << u;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; idle(); rel_req = '0; rd_done = '0;
        do_reset();

        // R1 reset state
        rel_req = '1;
        #1;
        chk("R1 go_store", go_store, 0);
        chk("R1 go_read", go_read, 0);
        chk("R1 issue_o", issue_o, 0);
        chk("R1 stall", stall, 0);
        @(negedge clk);
        rel_req = '0;

        // Vector walk: issue/stall decisions with accumulating state
        for (int i = 0; i < NV; i++) begin
            drv(TBL[i].unit, TBL[i].fi, TBL[i].fj, TBL[i].fk);
            #1;
            chk($sformatf("R2/R3/R4/R10/R12 vec%0d issue", i), issue_o,
                TBL[i].accept ? bit1(int'(TBL[i].unit)) : 16'd0);
            chk($sformatf("R2/R3/R4/R10/R12 vec%0d stall", i), stall, !TBL[i].accept);
            @(negedge clk);
        end
        idle();
        #1;
        // R5: add and multiply 7 have free sources; R6: multiply 6 and branch wait
        chk("R5 R6 go_read after walk", go_read, bit1(15) | bit1(7));
        chk("R4 unit_op add", unit_op[15], 6'd15);

        // Write-after-read hold and release
        do_reset();
        drv(4'd15, 5'd3, 5'd1, 5'd2);
        #1; chk("R4 add issue", issue_o, bit1(15));
        @(negedge clk);
        drv(4'd4, 5'd1, 5'd5, 5'd6);
        #1; chk("R8 boolean writes reg1 issues", issue_o, bit1(4));
        chk("R5 add go_read", go_read[15], 1);
        @(negedge clk);
        idle(); rel_req = bit1(4); rd_done = bit1(4);
        #1; chk("R8 go_store held by reader", go_store, 0);
        @(negedge clk);
        rd_done = bit1(15);
        #1; chk("R8 go_store still held", go_store, 0);
        @(negedge clk);
        rd_done = '0;
        #1; chk("R7 add go_read dropped", go_read[15], 0);
        chk("R8 go_store granted after read", go_store, bit1(4));
        @(negedge clk);
        rel_req = '0;
        drv(4'd4, 5'd1, 5'd0, 5'd0);
        #1; chk("R9 reissue same unit and register", issue_o, bit1(4));
        chk("R9 no stall", stall, 0);
        @(negedge clk);
        idle();

        // Read-after-write and same-cycle hand-off
        do_reset();
        drv(4'd6, 5'd8, 5'd1, 5'd2);
        @(negedge clk);
        drv(4'd15, 5'd9, 5'd8, 5'd3);
        #1; chk("R6 consumer issue", issue_o, bit1(15));
        @(negedge clk);
        drv(4'd3, 5'd10, 5'd8, 5'd4);
        rel_req = bit1(6);
        #1; chk("R6 consumer waits", go_read[15], 0);
        chk("R6 producer granted", go_store, bit1(6));
        chk("R13 issue during producer store", issue_o, bit1(3));
        @(negedge clk);
        idle(); rel_req = '0;
        #1; chk("R6 consumer go_read after store", go_read[15], 1);
        chk("R13 same-cycle consumer ready", go_read[3], 1);

        // Simultaneous grants to distinct registers
        do_reset();
        drv(4'd1, 5'd12, 5'd0, 5'd0);
        @(negedge clk);
        drv(4'd2, 5'd13, 5'd0, 5'd0);
        @(negedge clk);
        idle(); rel_req = bit1(1) | bit1(2);
        #1; chk("R11 both granted", go_store, bit1(1) | bit1(2));
        @(negedge clk);
        rel_req = '0;

        // Branch blocks issue until its store
        do_reset();
        drv(4'd0, 5'd16, 5'd0, 5'd0);
        @(negedge clk);
        drv(4'd4, 5'd17, 5'd0, 5'd0);
        rel_req = bit1(0);
        #1; chk("R10 blocked in branch store cycle", issue_o, 0);
        chk("R10 branch granted", go_store, bit1(0));
        @(negedge clk);
        rel_req = '0;
        #1; chk("R10 issue after branch done", issue_o, bit1(4));
        @(negedge clk);
        idle();

        done = 1;
        summary();
        $finish;
    end

endmodule